// File: doc/BRIEF.md
# Ping-Pong Audio Playback Fetch Engine

This block plays audio from a ring buffer in memory that is split into two equal halves. While playback is on, it reads one block of bytes at a time through a simple byte-wide read port. It turns those bytes into 16-bit stereo frames and hands them to the codec side over a valid/ready stream. When a block ends, the block raises a status flag that tells software which half it may refill. A block that started at the buffer start sets the "first half done" flag. The next block sets the "second half done" flag and sends the play pointer back to the start.

Software sets up the engine through a small register window. The window holds the sample format, the codec clock divider, the interrupt status and mask, the block threshold and the buffer base address. The engine also gives the bit-clock rate that the codec needs, as a plain number. This number comes from the selected base clock and the divider.

The engine is a four-state machine:
- IDLE waits until playback is on and the block size is legal, then goes to FETCH.
- FETCH reads bytes. It goes to EMIT when a frame is complete, or to FINISH when the block runs out in the middle of a frame.
- EMIT holds the frame until it is accepted. It then goes back to FETCH, or to FINISH at the end of the block.
- FINISH updates the position and the flags, then returns to IDLE.

An abort sends the machine to IDLE from any state. An abort is a disable, a base-address write or a divider write.

Top module: `pingpong_play_dma`

## Requirements
- R1: After reset, irq, mem_req and frm_valid are 0, and every register reads 0.
- R2: Reads return the stored value at offset 0x00 (mode), 0x18 (divider), 0x20 (status) and 0x24 (interrupt mask). Offset 0x38 returns the play position in bytes divided by 4. Other offsets read 0.
- R3: A threshold write of value v at 0x2C sets the block length to (v+1)*2 bytes. Block bytes are fetched one by one from base+position+i. The base takes bits 15:0 from a write at 0x28 and bits 31:16 from a write at 0x40.
- R4: With mode bit 0 = 1 (16-bit) and mode bit 14 = 0 (stereo), each 4 bytes form a frame: left = {b1,b0} and right = {b3,b2}, little-endian.
- R5: With 16-bit mono (bit 0 = 1, bit 14 = 1), each 2 bytes {b1,b0} go to both channels.
- R6: With 8-bit stereo (bit 0 = 0, bit 14 = 0), left = b0*256 and right = b1*256.
- R7: With 8-bit mono (bit 0 = 0, bit 14 = 1), each byte times 256 goes to both channels.
- R8: A block that started at position 0 sets status bit 6 and moves the position to the block length. Any other block sets status bit 7 and moves the position back to 0.
- R9: Writing status clears the bits written as 1. irq is 1 exactly when status AND mask is nonzero, and it follows mask writes at once.
- R10: Setting mode bit 7 when it was 0 clears status and position. A write to 0x28, 0x40 or 0x18 clears the position and restarts from the buffer start.
- R11: There is no memory read while mode bit 7 is 0. A block longer than MAX_BLOCK (4096) bytes is never fetched. A block of exactly 4096 bytes is fetched.
- R12: While frm_valid is 1 and frm_ready is 0, the frame stays on the port unchanged.
- R13: bclk_rate equals (24576000/64 when mode bit 9 is 1, else 11289600/64) divided by (divider bits 15:8 + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt, status AND mask |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_rvalid | input | 1 | Read data valid; accepts the request |
| mem_rdata | input | 8 | Read data byte |
| frm_valid | output | 1 | Frame valid |
| frm_ready | input | 1 | Frame accepted when high with valid |
| frm_left | output | 16 | Left sample |
| frm_right | output | 16 | Right sample |
| bclk_rate | output | 32 | Codec bit-clock rate in Hz |

## Verification
The main checks run all four sample formats over the same memory contents, so a swapped byte order, a missing mono copy or a missing shift by 8 gives a different frame. Each format plays two blocks in a row. This separates the first-half flag and position from the second-half ones, and checks that the pointer wraps. Further runs change the threshold, the low and high base halves and the divider. They also use a mask that covers only one flag. These runs show the block length, the address sum, the position reset and the interrupt masking. The stream is stalled on a fixed pattern to test the frame hold. Thresholds one step on each side of the 4096-byte limit test the size guard.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EMIT, ST_FINISH} eng_state_t;

    localparam logic [7:0] OFS_MODE    = 8'h00;
    localparam logic [7:0] OFS_CLKDIV  = 8'h18;
    localparam logic [7:0] OFS_STAT    = 8'h20;
    localparam logic [7:0] OFS_MASK    = 8'h24;
    localparam logic [7:0] OFS_BASE_LO = 8'h28;
    localparam logic [7:0] OFS_THRESH  = 8'h2C;
    localparam logic [7:0] OFS_POS     = 8'h38;
    localparam logic [7:0] OFS_BASE_HI = 8'h40;

    localparam int MB_WIDE = 0;
    localparam int MB_RUN  = 7;
    localparam int MB_FAST = 9;
    localparam int MB_MONO = 14;
    localparam int SB_HALF = 6;
    localparam int SB_FULL = 7;
endpackage

// File: rtl/pp_dma_rate.sv
module pp_dma_rate #(
    parameter int unsigned BASE_FAST_HZ = 24576000,
    parameter int unsigned BASE_SLOW_HZ = 11289600
) (
    input  logic        fast,
    input  logic [7:0]  div_sel,
    output logic [31:0] rate
);
    localparam logic [31:0] FAST_BCLK = 32'(BASE_FAST_HZ / 64);
    localparam logic [31:0] SLOW_BCLK = 32'(BASE_SLOW_HZ / 64);

    logic [31:0] base_sel;
    logic [31:0] divisor;

    always_comb begin
        base_sel = fast ? FAST_BCLK : SLOW_BCLK;
        divisor  = {24'd0, div_sel} + 32'd1;
        rate     = base_sel / divisor;
    end
endmodule

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
#(
    parameter int REG_AW    = 8,
    parameter int MAX_BLOCK = 4096,
    parameter int BLK_W     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [BLK_W-1:0]  pos,
    input  logic              set_half,
    input  logic              set_full,
    output logic [31:0]       rdata,
    output logic [31:0]       mode_q,
    output logic [31:0]       clkdiv_q,
    output logic [31:0]       base_q,
    output logic [BLK_W-1:0]  blk_bytes,
    output logic              blk_ok,
    output logic              pos_clr,
    output logic              irq
);
    localparam int THR_W = 35;

    logic [31:0]      mask_q;
    logic [1:0]       flag_q;
    logic [THR_W-1:0] thr_q;
    logic [THR_W-1:0] blk_full;
    logic [31:0]      stat_word;
    logic             run_rise;

    function automatic logic hit(input logic [REG_AW-1:0] a, input logic [7:0] ofs);
        return a == REG_AW'(ofs);
    endfunction

    always_comb begin
        run_rise  = we && hit(addr, OFS_MODE) && wdata[MB_RUN] && !mode_q[MB_RUN];
        pos_clr   = run_rise || (we && (hit(addr, OFS_BASE_LO) || hit(addr, OFS_BASE_HI)
                                     || hit(addr, OFS_CLKDIV)));
        blk_full  = thr_q >> 1;
        blk_ok    = (blk_full != '0) && (blk_full <= THR_W'(MAX_BLOCK));
        blk_bytes = blk_full[BLK_W-1:0];
        stat_word = '0;
        stat_word[SB_HALF] = flag_q[0];
        stat_word[SB_FULL] = flag_q[1];
        irq       = |(stat_word & mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            clkdiv_q <= '0;
            mask_q   <= '0;
            base_q   <= '0;
            thr_q    <= '0;
            flag_q   <= '0;
        end else begin
            if (we && hit(addr, OFS_MODE))    mode_q   <= wdata;
            if (we && hit(addr, OFS_CLKDIV))  clkdiv_q <= wdata;
            if (we && hit(addr, OFS_MASK))    mask_q   <= wdata;
            if (we && hit(addr, OFS_BASE_LO)) base_q[15:0]  <= wdata[15:0];
            if (we && hit(addr, OFS_BASE_HI)) base_q[31:16] <= wdata[15:0];
            if (we && hit(addr, OFS_THRESH))  thr_q <= ({3'd0, wdata} + THR_W'(1)) << 2;
            if (run_rise) begin
                flag_q <= '0;
            end else begin
                flag_q[0] <= (flag_q[0] && !(we && hit(addr, OFS_STAT) && wdata[SB_HALF])) || set_half;
                flag_q[1] <= (flag_q[1] && !(we && hit(addr, OFS_STAT) && wdata[SB_FULL])) || set_full;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit(addr, OFS_MODE))   rdata = mode_q;
        if (hit(addr, OFS_CLKDIV)) rdata = clkdiv_q;
        if (hit(addr, OFS_STAT))   rdata = stat_word;
        if (hit(addr, OFS_MASK))   rdata = mask_q;
        if (hit(addr, OFS_POS))    rdata = 32'(pos >> 2);
    end
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
    import pp_dma_pkg::*;
#(
    parameter int BLK_W = 13,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wide,
    input  logic             mono,
    input  logic [AW-1:0]    base_addr,
    input  logic [BLK_W-1:0] blk_bytes,
    input  logic             blk_ok,
    input  logic             pos_clr,
    input  logic             mem_rvalid,
    input  logic [7:0]       mem_rdata,
    input  logic             frm_ready,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             frm_valid,
    output logic [15:0]      frm_left,
    output logic [15:0]      frm_right,
    output logic [BLK_W-1:0] pos,
    output logic             set_half,
    output logic             set_full
);
    localparam int ASM_N = 4;

    eng_state_t       st_q, st_d;
    logic [BLK_W-1:0] cnt_q, blk_l, pos_q;
    logic [1:0]       idx_q, idx_last;
    logic             wide_l, mono_l, abort;
    logic [7:0]       asm_q [ASM_N];

    always_comb begin
        abort    = pos_clr || !en;
        idx_last = wide_l ? (mono_l ? 2'd1 : 2'd3) : (mono_l ? 2'd0 : 2'd1);
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (en && blk_ok) st_d = ST_FETCH;
            ST_FETCH:  if (mem_rvalid) begin
                           if (idx_q == idx_last)                   st_d = ST_EMIT;
                           else if ((cnt_q + BLK_W'(1)) == blk_l)   st_d = ST_FINISH;
                       end
            ST_EMIT:   if (frm_ready) st_d = (cnt_q == blk_l) ? ST_FINISH : ST_FETCH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
        if (abort) st_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        mem_req   = (st_q == ST_FETCH);
        frm_valid = (st_q == ST_EMIT);
        set_half  = (st_q == ST_FINISH) && !abort && (pos_q == '0);
        set_full  = (st_q == ST_FINISH) && !abort && (pos_q != '0);
        mem_addr  = base_addr + AW'(pos_q) + AW'(cnt_q);
        pos       = pos_q;
        unique case ({wide_l, mono_l})
            2'b10:   begin frm_left = {asm_q[1], asm_q[0]}; frm_right = {asm_q[3], asm_q[2]}; end
            2'b11:   begin frm_left = {asm_q[1], asm_q[0]}; frm_right = {asm_q[1], asm_q[0]}; end
            2'b00:   begin frm_left = {asm_q[0], 8'h00};    frm_right = {asm_q[1], 8'h00};    end
            default: begin frm_left = {asm_q[0], 8'h00};    frm_right = {asm_q[0], 8'h00};    end
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            blk_l  <= '0;
            pos_q  <= '0;
            idx_q  <= '0;
            wide_l <= 1'b0;
            mono_l <= 1'b0;
            for (int i = 0; i < ASM_N; i++) asm_q[i] <= '0;
        end else begin
            if (pos_clr)       pos_q <= '0;
            else if (set_half) pos_q <= blk_l;
            else if (set_full) pos_q <= '0;

            if (st_q == ST_IDLE && st_d == ST_FETCH) begin
                cnt_q  <= '0;
                idx_q  <= '0;
                wide_l <= wide;
                mono_l <= mono;
                blk_l  <= blk_bytes;
            end else if (st_q == ST_FETCH && mem_rvalid && !abort) begin
                asm_q[idx_q] <= mem_rdata;
                cnt_q        <= cnt_q + BLK_W'(1);
                idx_q        <= (idx_q == idx_last) ? 2'd0 : idx_q + 2'd1;
            end
        end
    end
endmodule

// File: rtl/pingpong_play_dma.sv
module pingpong_play_dma
    import pp_dma_pkg::*;
#(
    parameter int          REG_AW       = 8,
    parameter int          MAX_BLOCK    = 4096,
    parameter int unsigned BASE_FAST_HZ = 24576000,
    parameter int unsigned BASE_SLOW_HZ = 11289600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic [15:0]       frm_left,
    output logic [15:0]       frm_right,
    output logic [31:0]       bclk_rate
);
    localparam int BLK_W = $clog2(MAX_BLOCK + 1);

    logic [31:0]      mode_q, clkdiv_q, base_q;
    logic [BLK_W-1:0] blk_bytes, pos;
    logic             blk_ok, pos_clr, set_half, set_full;

    pp_dma_regs #(.REG_AW(REG_AW), .MAX_BLOCK(MAX_BLOCK), .BLK_W(BLK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .pos(pos), .set_half(set_half), .set_full(set_full), .rdata(reg_rdata),
        .mode_q(mode_q), .clkdiv_q(clkdiv_q), .base_q(base_q), .blk_bytes(blk_bytes),
        .blk_ok(blk_ok), .pos_clr(pos_clr), .irq(irq)
    );

    pp_dma_engine #(.BLK_W(BLK_W), .AW(32)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(mode_q[MB_RUN]), .wide(mode_q[MB_WIDE]),
        .mono(mode_q[MB_MONO]), .base_addr(base_q), .blk_bytes(blk_bytes), .blk_ok(blk_ok),
        .pos_clr(pos_clr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .frm_ready(frm_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .frm_valid(frm_valid), .frm_left(frm_left), .frm_right(frm_right),
        .pos(pos), .set_half(set_half), .set_full(set_full)
    );

    pp_dma_rate #(.BASE_FAST_HZ(BASE_FAST_HZ), .BASE_SLOW_HZ(BASE_SLOW_HZ)) u_rate (
        .fast(mode_q[MB_FAST]), .div_sel(clkdiv_q[15:8]), .rate(bclk_rate)
    );
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk #(parameter int BLK_W = 13) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             pos_clr,
    input logic             set_half,
    input logic             set_full,
    input logic [BLK_W-1:0] pos,
    input logic             mem_req,
    input logic             frm_valid,
    input logic             frm_ready,
    input logic [15:0]      frm_left,
    input logic [15:0]      frm_right
);
    p_frame_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready && en && !pos_clr) |=> (frm_valid && $stable(frm_left) && $stable(frm_right)));

    p_no_fetch_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mem_req);

    p_pos_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pos_clr |=> (pos == '0));

    p_half_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_half && !pos_clr) |=> (pos != '0));

    p_full_wraps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_full && !pos_clr) |=> (pos == '0));

    p_req_or_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, frm_valid, set_half || set_full}));
endmodule

bind pingpong_play_dma pp_dma_chk #(.BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(mode_q[7]), .pos_clr(pos_clr), .set_half(set_half),
    .set_full(set_full), .pos(pos), .mem_req(mem_req), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_left(frm_left), .frm_right(frm_right)
);

// File: tb/pingpong_play_dma_tb.sv
`timescale 1ns/1ps
module pingpong_play_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, frm_valid;
    logic [31:0] mem_addr, bclk_rate;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        frm_ready = 1'b0;
    logic [15:0] frm_left, frm_right;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] expq [$];

    always #4 clk = ~clk;

    pingpong_play_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .frm_valid(frm_valid),
        .frm_ready(frm_ready), .frm_left(frm_left), .frm_right(frm_right), .bclk_rate(bclk_rate)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] * 8'd7 + a[15:8] + a[16 +: 8] + 8'h13;
    endfunction

    // memory model: one byte per request, every other cycle
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_rvalid;
        mem_rdata  <= mem_byte(mem_addr);
    end

    // ready: only while a frame is expected, stalled every third cycle
    int rc = 0;
    always @(posedge clk) begin
        #1;
        rc++;
        frm_ready = (expq.size() > 0) && (rc % 3 != 2);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    bit hold_pend = 0;
    logic [31:0] hold_val;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && expq.size() > 0)
                chk(frm_valid && {frm_left, frm_right} == hold_val, "R12", "frame hold",
                    {frm_left, frm_right}, hold_val);
            hold_pend = frm_valid && !frm_ready && expq.size() > 0;
            hold_val  = {frm_left, frm_right};
            if (frm_valid && frm_ready) begin
                if (expq.size() == 0) chk(0, "R3", "unexpected frame", {frm_left, frm_right}, 0);
                else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    chk({frm_left, frm_right} == e, "R4-7fmt", "frame", {frm_left, frm_right}, e);
                end
            end
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: push the frames one block should produce (R3 addressing, R4..R7 formats)
    task automatic push_block(input logic [31:0] base, input int p, input int nb,
                              input bit wide, input bit mono);
        int fb;
        fb = (wide ? 2 : 1) * (mono ? 1 : 2);
        for (int i = 0; i + fb <= nb; i += fb) begin
            logic [7:0] b [4];
            logic [15:0] l, r;
            for (int k = 0; k < fb; k++) b[k] = mem_byte(base + p + i + k);
            if (wide && !mono)      begin l = {b[1], b[0]}; r = {b[3], b[2]}; end
            else if (wide && mono)  begin l = {b[1], b[0]}; r = l; end
            else if (!mono)         begin l = {b[0], 8'h00}; r = {b[1], 8'h00}; end
            else                    begin l = {b[0], 8'h00}; r = l; end
            expq.push_back({l, r});
        end
    endtask

    task automatic wait_drain;
        while (expq.size() > 0) @(posedge clk);
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic check_state(input logic [31:0] st, input logic [31:0] ps, input string req);
        logic [31:0] d;
        reg_read(8'h20, d); chk(d == st, req, "status", d, st);
        reg_read(8'h38, d); chk(d == ps, req, "position/4", d, ps);
    endtask

    task automatic run_format(input logic [31:0] mode, input bit wide, input bit mono, input string req);
        reg_write(8'h00, 32'h0);
        reg_write(8'h00, mode);
        check_state(32'h0, 32'h0, "R10");
        push_block(32'h100, 0, 8, wide, mono);
        wait_drain();
        check_state(32'h40, 32'h2, "R8");
        chk(irq == 1'b1, req, "irq after half", irq, 1);
        push_block(32'h100, 8, 8, wide, mono);
        wait_drain();
        check_state(32'hC0, 32'h0, "R8");
    endtask

    task automatic count_req(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk); c += (mem_req || frm_valid); end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int c;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1
        chk(irq == 0, "R1", "irq", irq, 0);
        chk(mem_req == 0, "R1", "mem_req", mem_req, 0);
        chk(frm_valid == 0, "R1", "frm_valid", frm_valid, 0);
        reg_read(8'h00, d); chk(d == 0, "R1", "mode", d, 0);
        reg_read(8'h20, d); chk(d == 0, "R1", "status", d, 0);
        // R2
        reg_write(8'h24, 32'hC0);
        reg_read(8'h24, d); chk(d == 32'hC0, "R2", "mask", d, 32'hC0);
        reg_write(8'h18, 32'h0300);
        reg_read(8'h18, d); chk(d == 32'h0300, "R2", "divider", d, 32'h0300);
        reg_read(8'h2C, d); chk(d == 0, "R2", "unlisted offset", d, 0);
        // R13
        chk(bclk_rate == 32'd44100, "R13", "slow/4", bclk_rate, 44100);
        reg_write(8'h00, 32'h200);
        chk(bclk_rate == 32'd96000, "R13", "fast/4", bclk_rate, 96000);
        reg_write(8'h00, 32'h0);
        reg_write(8'h18, 32'h0);
        chk(bclk_rate == 32'd176400, "R13", "slow/1", bclk_rate, 176400);
        // buffer at 0x100, threshold 3 -> 8-byte blocks
        reg_write(8'h28, 32'h0100);
        reg_write(8'h40, 32'h0000);
        reg_write(8'h2C, 32'd3);
        run_format(32'h0081, 1, 0, "R4");
        run_format(32'h4081, 1, 1, "R5");
        run_format(32'h0080, 0, 0, "R6");
        run_format(32'h4080, 0, 1, "R7");
        // R9
        reg_write(8'h20, 32'h40);
        reg_read(8'h20, d); chk(d == 32'h80, "R9", "w1c half", d, 32'h80);
        chk(irq == 1, "R9", "irq full only", irq, 1);
        reg_write(8'h24, 32'h40);
        chk(irq == 0, "R9", "irq masked", irq, 0);
        reg_write(8'h24, 32'h80);
        chk(irq == 1, "R9", "irq unmasked", irq, 1);
        reg_write(8'h20, 32'h80);
        reg_read(8'h20, d); chk(d == 0, "R9", "w1c full", d, 0);
        chk(irq == 0, "R9", "irq cleared", irq, 0);
        reg_write(8'h24, 32'hC0);
        // R10: base write restarts from the buffer start
        push_block(32'h100, 0, 8, 0, 1);
        wait_drain();
        check_state(32'h40, 32'h2, "R8");
        reg_write(8'h20, 32'hC0);
        reg_write(8'h28, 32'h0200);
        reg_read(8'h38, d); chk(d == 0, "R10", "pos after base write", d, 0);
        push_block(32'h200, 0, 8, 0, 1);
        wait_drain();
        check_state(32'h40, 32'h2, "R10");
        // R3: threshold 1 -> 4-byte blocks
        reg_write(8'h2C, 32'd1);
        reg_write(8'h00, 32'h0);
        reg_write(8'h00, 32'h0081);
        push_block(32'h200, 0, 4, 1, 0);
        wait_drain();
        check_state(32'h40, 32'h1, "R3");
        push_block(32'h200, 4, 4, 1, 0);
        wait_drain();
        check_state(32'hC0, 32'h0, "R3");
        reg_write(8'h40, 32'h0001);
        reg_read(8'h38, d); chk(d == 0, "R10", "pos after high write", d, 0);
        push_block(32'h10200, 0, 4, 1, 0);
        wait_drain();
        reg_read(8'h38, d); chk(d == 1, "R3", "high base block pos", d, 1);
        // R11
        reg_write(8'h00, 32'h0);
        repeat (2) @(posedge clk);
        count_req(30, c); chk(c == 0, "R11", "activity while off", c, 0);
        reg_write(8'h2C, 32'd2048);
        reg_write(8'h00, 32'h0081);
        count_req(40, c); chk(c == 0, "R11", "activity oversize", c, 0);
        reg_write(8'h00, 32'h0);
        reg_write(8'h2C, 32'd2047);
        reg_write(8'h00, 32'h0081);
        count_req(40, c); chk(c > 0, "R11", "activity at 4096", c, 1);
        reg_write(8'h00, 32'h0);
        repeat (4) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule